// File: doc/BRIEF.md
# Packet Receive Buffer with Release Gating

This block sits between a network receiver and the logic that drains received frames. The receiver pushes 64-bit entries into it, and each entry carries a start-of-packet mark and an end-of-packet mark. The buffer holds back the beginning of every packet. The reader sees none of a new packet until a programmable number of that packet's entries has arrived, or until the packet ends, whichever comes first. After a packet has been released, each later entry of the same packet becomes readable on the cycle after it is written.

The write port has a valid signal only, because a receiver cannot be stalled. An entry offered when the buffer is full is dropped. The drop sets a sticky overflow flag, and that flag is cleared by a one-cycle clear pulse. The read port uses valid/ready. `rd_valid` is high whenever at least one released entry is stored. An entry leaves the buffer on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, the presented entry and its marks are held unchanged.

Two plain status outputs are also provided. `data_avail` reports that enough released entries are stored to meet a read threshold; DMA-style readers use a threshold of 4. `fc_req` asks the link for flow control while free space is below a watermark; the suggested watermark is 4. All three thresholds are 6-bit inputs. The release threshold should be set to 3 or more.

Top module: `rx_release_fifo`

## Requirements
- R1: After reset the buffer is empty: `rd_valid`=0, `data_avail`=0, `ovf`=0, and `fc_req`=0 for any watermark up to the depth.
- R2: The entries of a packet are not readable while the number of its entries written (counting the start entry as 1) is below `cfg_rel_thr`. The write that brings this count up to the threshold makes all of the packet's stored entries readable on the following cycle.
- R3: A packet that ends before it reaches the release threshold becomes readable in full on the cycle after its end-of-packet write.
- R4: After a packet has been released, each further entry written for it is readable on the next cycle.
- R5: Entries leave in write order, with their start/end marks, only on edges where `rd_valid` and `rd_ready` are both 1. While `rd_ready` is 0 the presented data is held stable.
- R6: `data_avail` is 1 exactly when the number of readable entries is nonzero and is at least `cfg_rd_thr`.
- R7: `fc_req` is 1 exactly when the number of free entries (depth minus stored) is below `cfg_fc_thr`. It drops as soon as free space returns to the watermark, with no hysteresis.
- R8: A write offered while all DEPTH (default 32) entries are in use is dropped and leaves the stored content unchanged. It sets `ovf`, which stays at 1 until an `ovf_clr` pulse. A drop in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Receiver offers an entry |
| wr_data | input | 64 | Entry payload |
| wr_sop | input | 1 | Entry opens a packet |
| wr_eop | input | 1 | Entry closes a packet |
| rd_valid | output | 1 | A released entry is presented |
| rd_ready | input | 1 | Reader takes the presented entry |
| rd_data | output | 64 | Presented payload |
| rd_sop | output | 1 | Presented entry opens a packet |
| rd_eop | output | 1 | Presented entry closes a packet |
| data_avail | output | 1 | Released entries meet the read threshold |
| fc_req | output | 1 | Free space below the watermark |
| ovf | output | 1 | Sticky dropped-write flag |
| ovf_clr | input | 1 | Clears the dropped-write flag |
| cfg_rd_thr | input | 6 | Read threshold |
| cfg_rel_thr | input | 6 | Release threshold |
| cfg_fc_thr | input | 6 | Free-space watermark |

## Verification
The release gate is exercised with three patterns. A long packet crossing the threshold shows that nothing leaks early and that everything appears on the crossing write. A two-entry packet that ends under a high threshold shows that the end mark alone releases it. A released packet that keeps growing shows that its tail becomes visible per entry. A filling sequence walks free space across the watermark in both directions and then past full, which separates the flow-control compare, the drop-on-full path and the sticky flag. A stalled read confirms that held data does not move.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned ENTRY_W = 64;

  typedef struct packed {
    logic               sop;
    logic               eop;
    logic [ENTRY_W-1:0] data;
  } rxr_entry_t;
endpackage

// File: rtl/rxr_store.sv
module rxr_store
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  rxr_entry_t push_ent,
  input  logic       pop,
  output rxr_entry_t head_ent,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] used,
  output logic          full
);
  rxr_entry_t mem [DEPTH];

  assign used     = wr_ptr - rd_ptr;
  assign full     = (used == PW'(DEPTH));
  assign head_ent = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr[AW-1:0]] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop)           rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // occupancy never exceeds the storage
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));

  // a full buffer refuses the write
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |=> (wr_ptr == $past(wr_ptr)));
endmodule

// File: rtl/rxr_gate.sv
module rxr_gate #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned THR_W = 6,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sop,
  input  logic             eop,
  input  logic [THR_W-1:0] rel_thr,
  input  logic [PW-1:0]    wr_ptr,
  input  logic [PW-1:0]    rd_ptr,
  output logic [PW-1:0]    vis_ptr
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic             in_pkt;
  logic             released;
  logic [THR_W-1:0] pkt_cnt;
  logic             opening;
  logic [THR_W-1:0] cnt_nx;
  logic             let_go;

  assign opening = sop || !in_pkt;

  always_comb begin
    if (opening)                cnt_nx = THR_W'(1);
    else if (pkt_cnt == CNT_MAX) cnt_nx = pkt_cnt;
    else                        cnt_nx = pkt_cnt + 1'b1;
  end

  assign let_go = (!opening && released) || (cnt_nx >= rel_thr) || eop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      released <= 1'b0;
      pkt_cnt  <= '0;
      vis_ptr  <= '0;
    end else if (accept) begin
      in_pkt   <= !eop;
      released <= let_go && !eop;
      pkt_cnt  <= cnt_nx;
      if (let_go) vis_ptr <= wr_ptr + 1'b1;
    end
  end

  // visible region lies inside the stored region
  assert_vis_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_ptr - rd_ptr) <= (wr_ptr - rd_ptr));

  // an accepted end mark exposes everything written
  assert_eop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && eop) |=> (vis_ptr == wr_ptr));
endmodule

// File: rtl/rxr_level.sv
module rxr_level #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned THR_W = 6,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1,
  localparam int unsigned CW = (PW > THR_W) ? PW : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    used,
  input  logic [PW-1:0]    ready_cnt,
  input  logic [THR_W-1:0] rd_thr,
  input  logic [THR_W-1:0] fc_thr,
  input  logic             drop,
  input  logic             clr,
  output logic             avail,
  output logic             fc_req,
  output logic             ovf
);
  logic [CW-1:0] free_w;
  logic [CW-1:0] rdy_w;

  assign free_w = CW'(DEPTH) - CW'(used);
  assign rdy_w  = CW'(ready_cnt);
  assign avail  = (rdy_w != '0) && (rdy_w >= CW'(rd_thr));
  assign fc_req = free_w < CW'(fc_thr);

  always_ff @(posedge clk) begin
    if (!rst_n)    ovf <= 1'b0;
    else if (drop) ovf <= 1'b1;
    else if (clr)  ovf <= 1'b0;
  end

  assert_drop_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
endmodule

// File: rtl/rx_release_fifo.sv
module rx_release_fifo
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned THR_W = 6,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               wr_sop,
  input  logic               wr_eop,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rd_sop,
  output logic               rd_eop,
  output logic               data_avail,
  output logic               fc_req,
  output logic               ovf,
  input  logic               ovf_clr,
  input  logic [THR_W-1:0]   cfg_rd_thr,
  input  logic [THR_W-1:0]   cfg_rel_thr,
  input  logic [THR_W-1:0]   cfg_fc_thr
);
  rxr_entry_t   in_ent;
  rxr_entry_t   head;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] used;
  logic [PW-1:0] vis_ptr;
  logic [PW-1:0] ready_cnt;
  logic          full;
  logic          accept;
  logic          pop;

  assign in_ent    = '{sop: wr_sop, eop: wr_eop, data: wr_data};
  assign accept    = wr_valid && !full;
  assign ready_cnt = vis_ptr - rd_ptr;
  assign rd_valid  = (ready_cnt != '0);
  assign pop       = rd_valid && rd_ready;
  assign rd_data   = head.data;
  assign rd_sop    = head.sop;
  assign rd_eop    = head.eop;

  rxr_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(wr_valid), .push_ent(in_ent),
    .pop(pop), .head_ent(head),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .used(used), .full(full)
  );

  rxr_gate #(.DEPTH(DEPTH), .THR_W(THR_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .sop(wr_sop), .eop(wr_eop),
    .rel_thr(cfg_rel_thr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .vis_ptr(vis_ptr)
  );

  rxr_level #(.DEPTH(DEPTH), .THR_W(THR_W)) u_level (
    .clk(clk), .rst_n(rst_n),
    .used(used), .ready_cnt(ready_cnt),
    .rd_thr(cfg_rd_thr), .fc_thr(cfg_fc_thr),
    .drop(wr_valid && full), .clr(ovf_clr),
    .avail(data_avail), .fc_req(fc_req), .ovf(ovf)
  );

  // a stalled read holds its entry
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/sim_rx_release_fifo.sv
module sim_rx_release_fifo;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_sop = 1'b0;
  logic        wr_eop = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [63:0] rd_data;
  logic        rd_sop;
  logic        rd_eop;
  logic        data_avail;
  logic        fc_req;
  logic        ovf;
  logic        ovf_clr = 1'b0;
  logic [5:0]  cfg_rd_thr = 6'd4;
  logic [5:0]  cfg_rel_thr = 6'd4;
  logic [5:0]  cfg_fc_thr = 6'd4;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_release_fifo u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_sop(rd_sop), .rd_eop(rd_eop),
    .data_avail(data_avail), .fc_req(fc_req), .ovf(ovf), .ovf_clr(ovf_clr),
    .cfg_rd_thr(cfg_rd_thr), .cfg_rel_thr(cfg_rel_thr), .cfg_fc_thr(cfg_fc_thr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write; returns just after the edge that takes it
  task automatic put(input logic [63:0] d, input logic s, input logic e);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
  endtask

  // one read with content check
  task automatic take(input string req, input logic [63:0] d, input logic s, input logic e);
    @(negedge clk);
    rd_ready = 1'b1; #1;
    chk(req, rd_valid, 1'b1);
    chk(req, rd_data, d);
    chk(req, {rd_sop, rd_eop}, {s, e});
    @(posedge clk); #1;
    rd_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 data_avail", data_avail, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 fc_req", fc_req, 0);
  endtask

  task automatic t_threshold_release;
    cfg_rel_thr = 6'd4; cfg_rd_thr = 6'd4;
    put(64'hA0, 1, 0); chk("R2 held 1", rd_valid, 0);
    put(64'hA1, 0, 0); chk("R2 held 2", rd_valid, 0);
    put(64'hA2, 0, 0); chk("R2 held 3", rd_valid, 0);
    put(64'hA3, 0, 0); chk("R2 released", rd_valid, 1);
    chk("R6 avail at 4", data_avail, 1);
    put(64'hA4, 0, 1);
    take("R5 order", 64'hA0, 1, 0);
    take("R5 order", 64'hA1, 0, 0);
    chk("R6 below thr", data_avail, 0);
    take("R5 order", 64'hA2, 0, 0);
    take("R5 order", 64'hA3, 0, 0);
    take("R5 order", 64'hA4, 0, 1);
    chk("R5 empty", rd_valid, 0);
  endtask

  task automatic t_short_packet;
    cfg_rel_thr = 6'd8;
    put(64'hB0, 1, 0); chk("R3 held", rd_valid, 0);
    put(64'hB1, 0, 1); chk("R3 eop release", rd_valid, 1);
    take("R3 data", 64'hB0, 1, 0);
    take("R3 data", 64'hB1, 0, 1);
  endtask

  task automatic t_tail_growth;
    cfg_rel_thr = 6'd3; cfg_rd_thr = 6'd4;
    put(64'hC0, 1, 0); put(64'hC1, 0, 0); put(64'hC2, 0, 0);
    chk("R4 released", rd_valid, 1);
    chk("R6 three of four", data_avail, 0);
    put(64'hC3, 0, 1);
    chk("R4 tail visible", data_avail, 1);
    take("R4 data", 64'hC0, 1, 0); take("R4 data", 64'hC1, 0, 0);
    take("R4 data", 64'hC2, 0, 0); take("R4 data", 64'hC3, 0, 1);
  endtask

  task automatic t_stall;
    cfg_rel_thr = 6'd3;
    put(64'hD0, 1, 1);
    put(64'hD1, 1, 1);
    repeat (3) @(posedge clk);
    #1;
    chk("R5 stall valid", rd_valid, 1);
    chk("R5 stall data", rd_data, 64'hD0);
    take("R5 pop", 64'hD0, 1, 1);
    take("R5 pop", 64'hD1, 1, 1);
    chk("R5 drained", rd_valid, 0);
  endtask

  task automatic t_fill;
    cfg_rel_thr = 6'd3; cfg_fc_thr = 6'd4;
    for (int i = 0; i < 28; i++) put(64'h1000 + i, i == 0, 0);
    chk("R7 free 4", fc_req, 0);
    put(64'h1000 + 28, 0, 0);
    chk("R7 free 3", fc_req, 1);
    take("R7 read", 64'h1000, 1, 0);
    chk("R7 no hysteresis", fc_req, 0);
    for (int i = 29; i < 33; i++) put(64'h1000 + i, 0, 0);
    chk("R8 no ovf yet", ovf, 0);
    put(64'hDEAD, 0, 1);
    chk("R8 ovf set", ovf, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(posedge clk); #1; ovf_clr = 1'b0;
    chk("R8 ovf cleared", ovf, 0);
    for (int i = 1; i < 33; i++) take("R8 content", 64'h1000 + i, 0, 0);
    chk("R8 dropped entry absent", rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    #1; t_reset();
    t_threshold_release();
    t_short_packet();
    t_tail_growth();
    t_stall();
    t_fill();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule